// File: doc/BRIEF.md
# Five-Stage Pipeline Inter-Stage Register Chain

This block holds the state that an in-order five-stage pipeline carries between its stages: fetch to decode, decode to execute, execute to memory, and memory to writeback. Each register samples the combinational outputs of the stage in front of it at every rising clock edge. It passes the captured values to the stage behind it.

Control fields are grouped by the stage that consumes them. The decode/execute register carries execute, memory and writeback controls. The execute/memory register keeps only the memory and writeback groups. The memory/writeback register keeps only the writeback group. The destination register number travels along with the writeback controls all the way to writeback.

Each register has its own flush and hold input, so that an external hazard unit can insert a bubble or stall one slot. A bubble is an all-zero register: the all-zero instruction word is the no-op, and every control enable is off. The hazard logic, ALU, register file, memories and decoder sit outside this block.

Top module: `pipe_stage_chain`

## Requirements
- R1: When `rst` is high at a rising edge, every register is loaded with all zeros. After that edge every output is zero.
- R2: The fetch/decode register captures `if_instr` at each edge where it is neither flushed nor held, and presents it on `id_instr`.
- R3: The decode/execute register captures the ALU opcode, the immediate-select bit, the memory read and write enables, the writeback enable, the memory-to-register select, the destination index, both register operands and the immediate from the decode-side inputs.
- R4: The execute/memory register captures `ex_alu_res` together with these fields from the decode/execute register: the memory controls, the writeback controls, the destination index, and the second register operand (as the store value). It drops the execute controls.
- R5: The memory/writeback register captures `mem_rdata` together with these fields from the execute/memory register: the ALU result, the writeback controls and the destination index. It drops the memory controls.
- R6: Bit k of `stage_flush` (0 = fetch/decode, 1 = decode/execute, 2 = execute/memory, 3 = memory/writeback) loads all zeros into register k at the next edge. Flush takes precedence over bit k of `stage_hold`.
- R7: Bit k of `stage_hold`, when not flushed, keeps register k unchanged across the edge. The other registers still advance.
- R8: With no flush or hold, a destination index and a writeback enable that enter the decode/execute register appear on `mw_rd` and `mw_reg_we` exactly two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, loads bubbles |
| stage_flush | input | 4 | Per-register flush (bit 0 = fetch/decode) |
| stage_hold | input | 4 | Per-register hold (bit 0 = fetch/decode) |
| if_instr | input | 32 | Fetched instruction word |
| id_alu_op | input | 4 | Decoded ALU opcode |
| id_alu_imm | input | 1 | Decoded select: immediate as second ALU operand |
| id_mem_rd | input | 1 | Decoded memory read enable |
| id_mem_wr | input | 1 | Decoded memory write enable |
| id_reg_we | input | 1 | Decoded register write enable |
| id_mem_to_reg | input | 1 | Decoded select: writeback takes memory data |
| id_rd | input | 5 | Decoded destination register index |
| id_rs_val | input | 32 | First register-file read value |
| id_rt_val | input | 32 | Second register-file read value |
| id_imm | input | 32 | Extended immediate |
| ex_alu_res | input | 32 | ALU result from execute |
| mem_rdata | input | 32 | Data memory read word |
| id_instr | output | 32 | Instruction for decode |
| dx_alu_op | output | 4 | ALU opcode for execute |
| dx_alu_imm | output | 1 | Immediate-select for execute |
| dx_mem_rd | output | 1 | Memory read enable in execute slot |
| dx_mem_wr | output | 1 | Memory write enable in execute slot |
| dx_reg_we | output | 1 | Write enable in execute slot |
| dx_mem_to_reg | output | 1 | Writeback select in execute slot |
| dx_rd | output | 5 | Destination index in execute slot |
| dx_rs_val | output | 32 | First operand for execute |
| dx_rt_val | output | 32 | Second operand for execute |
| dx_imm | output | 32 | Immediate for execute |
| xm_alu_res | output | 32 | ALU result / address for memory |
| xm_store_val | output | 32 | Store data for memory |
| xm_mem_rd | output | 1 | Memory read enable |
| xm_mem_wr | output | 1 | Memory write enable |
| xm_reg_we | output | 1 | Write enable in memory slot |
| xm_mem_to_reg | output | 1 | Writeback select in memory slot |
| xm_rd | output | 5 | Destination index in memory slot |
| mw_rdata | output | 32 | Memory read word for writeback |
| mw_alu_res | output | 32 | ALU result for writeback |
| mw_reg_we | output | 1 | Register file write enable |
| mw_mem_to_reg | output | 1 | Writeback data select |
| mw_rd | output | 5 | Register file write index |

## Verification
The hardest situation to reach is the one where neighbouring registers get different commands at the same edge. One example is a held register whose upstream neighbour is flushed. Another is a held register whose downstream neighbour keeps advancing, so that the neighbour captures the same frozen values twice. Another is flush and hold asserted together on the same register. Random stimulus draws each flush and hold bit on its own at low rates, so these mixed cases keep occurring. Directed sequences then force the flush-plus-hold collision, a multi-cycle hold, a reset in the middle of the run and a clean pass of one destination index through the chain.

// File: rtl/pipe_chain_pkg.sv
package pipe_chain_pkg;

    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int ALUOP_W = 4;
    localparam int NSLOT   = 4;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic               alu_imm;
    } ex_ctl_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_we;
        logic mem_to_reg;
    } wb_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
    } fd_slot_t;

    typedef struct packed {
        ex_ctl_t           ex;
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   rs_val;
        logic [XLEN-1:0]   rt_val;
        logic [XLEN-1:0]   imm;
    } dx_slot_t;

    typedef struct packed {
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   alu_res;
        logic [XLEN-1:0]   store_val;
    } xm_slot_t;

    typedef struct packed {
        wb_ctl_t           wb;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   rdata;
        logic [XLEN-1:0]   alu_res;
    } mw_slot_t;

endpackage

// File: rtl/stage_slot.sv
module stage_slot #(
    parameter type SLOT_T = logic [7:0]
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  hold,
    input  SLOT_T slot_in,
    output SLOT_T slot_out
);

    SLOT_T slot_d;
    SLOT_T slot_q;

    // Priority: reset, then flush, then hold, then load.
    always_comb begin
        slot_d = slot_in;
        if (rst || flush) begin
            slot_d = '0;
        end else if (hold) begin
            slot_d = slot_q;
        end
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign slot_out = slot_q;

    AST_RESET_BUBBLE: assert property (@(posedge clk)
        $past(rst) |-> slot_q == '0);                                   // R1
    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> slot_q == '0);                                 // R6
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flush) && $past(hold)) |-> $stable(slot_q)); // R7
    AST_LOAD_INPUT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flush) && !$past(hold)) |-> slot_q == $past(slot_in)); // R2

endmodule

// File: rtl/pipe_stage_chain.sv
module pipe_stage_chain
    import pipe_chain_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSLOT-1:0]   stage_flush,
    input  logic [NSLOT-1:0]   stage_hold,
    input  logic [XLEN-1:0]    if_instr,
    input  logic [ALUOP_W-1:0] id_alu_op,
    input  logic               id_alu_imm,
    input  logic               id_mem_rd,
    input  logic               id_mem_wr,
    input  logic               id_reg_we,
    input  logic               id_mem_to_reg,
    input  logic [RIDX_W-1:0]  id_rd,
    input  logic [XLEN-1:0]    id_rs_val,
    input  logic [XLEN-1:0]    id_rt_val,
    input  logic [XLEN-1:0]    id_imm,
    input  logic [XLEN-1:0]    ex_alu_res,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic [XLEN-1:0]    id_instr,
    output logic [ALUOP_W-1:0] dx_alu_op,
    output logic               dx_alu_imm,
    output logic               dx_mem_rd,
    output logic               dx_mem_wr,
    output logic               dx_reg_we,
    output logic               dx_mem_to_reg,
    output logic [RIDX_W-1:0]  dx_rd,
    output logic [XLEN-1:0]    dx_rs_val,
    output logic [XLEN-1:0]    dx_rt_val,
    output logic [XLEN-1:0]    dx_imm,
    output logic [XLEN-1:0]    xm_alu_res,
    output logic [XLEN-1:0]    xm_store_val,
    output logic               xm_mem_rd,
    output logic               xm_mem_wr,
    output logic               xm_reg_we,
    output logic               xm_mem_to_reg,
    output logic [RIDX_W-1:0]  xm_rd,
    output logic [XLEN-1:0]    mw_rdata,
    output logic [XLEN-1:0]    mw_alu_res,
    output logic               mw_reg_we,
    output logic               mw_mem_to_reg,
    output logic [RIDX_W-1:0]  mw_rd
);

    localparam int FD = 0;
    localparam int DX = 1;
    localparam int XM = 2;
    localparam int MW = 3;

    fd_slot_t fd_d, fd_q;
    dx_slot_t dx_d, dx_q;
    xm_slot_t xm_d, xm_q;
    mw_slot_t mw_d, mw_q;

    // Next-slot contents: each later slot keeps only what its remaining stages use.
    always_comb begin
        fd_d.instr         = if_instr;

        dx_d.ex.alu_op     = id_alu_op;
        dx_d.ex.alu_imm    = id_alu_imm;
        dx_d.mem.rd_en     = id_mem_rd;
        dx_d.mem.wr_en     = id_mem_wr;
        dx_d.wb.reg_we     = id_reg_we;
        dx_d.wb.mem_to_reg = id_mem_to_reg;
        dx_d.rd            = id_rd;
        dx_d.rs_val        = id_rs_val;
        dx_d.rt_val        = id_rt_val;
        dx_d.imm           = id_imm;

        xm_d.mem           = dx_q.mem;
        xm_d.wb            = dx_q.wb;
        xm_d.rd            = dx_q.rd;
        xm_d.alu_res       = ex_alu_res;
        xm_d.store_val     = dx_q.rt_val;

        mw_d.wb            = xm_q.wb;
        mw_d.rd            = xm_q.rd;
        mw_d.rdata         = mem_rdata;
        mw_d.alu_res       = xm_q.alu_res;
    end

    stage_slot #(.SLOT_T(fd_slot_t)) u_fd (
        .clk(clk), .rst(rst), .flush(stage_flush[FD]), .hold(stage_hold[FD]),
        .slot_in(fd_d), .slot_out(fd_q));
    stage_slot #(.SLOT_T(dx_slot_t)) u_dx (
        .clk(clk), .rst(rst), .flush(stage_flush[DX]), .hold(stage_hold[DX]),
        .slot_in(dx_d), .slot_out(dx_q));
    stage_slot #(.SLOT_T(xm_slot_t)) u_xm (
        .clk(clk), .rst(rst), .flush(stage_flush[XM]), .hold(stage_hold[XM]),
        .slot_in(xm_d), .slot_out(xm_q));
    stage_slot #(.SLOT_T(mw_slot_t)) u_mw (
        .clk(clk), .rst(rst), .flush(stage_flush[MW]), .hold(stage_hold[MW]),
        .slot_in(mw_d), .slot_out(mw_q));

    assign id_instr      = fd_q.instr;
    assign dx_alu_op     = dx_q.ex.alu_op;
    assign dx_alu_imm    = dx_q.ex.alu_imm;
    assign dx_mem_rd     = dx_q.mem.rd_en;
    assign dx_mem_wr     = dx_q.mem.wr_en;
    assign dx_reg_we     = dx_q.wb.reg_we;
    assign dx_mem_to_reg = dx_q.wb.mem_to_reg;
    assign dx_rd         = dx_q.rd;
    assign dx_rs_val     = dx_q.rs_val;
    assign dx_rt_val     = dx_q.rt_val;
    assign dx_imm        = dx_q.imm;
    assign xm_alu_res    = xm_q.alu_res;
    assign xm_store_val  = xm_q.store_val;
    assign xm_mem_rd     = xm_q.mem.rd_en;
    assign xm_mem_wr     = xm_q.mem.wr_en;
    assign xm_reg_we     = xm_q.wb.reg_we;
    assign xm_mem_to_reg = xm_q.wb.mem_to_reg;
    assign xm_rd         = xm_q.rd;
    assign mw_rdata      = mw_q.rdata;
    assign mw_alu_res    = mw_q.alu_res;
    assign mw_reg_we     = mw_q.wb.reg_we;
    assign mw_mem_to_reg = mw_q.wb.mem_to_reg;
    assign mw_rd         = mw_q.rd;

    AST_XM_FROM_DX: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stage_flush[XM]) && !$past(stage_hold[XM]))
        |-> (xm_rd == $past(dx_rd) && xm_store_val == $past(dx_rt_val)
             && xm_mem_wr == $past(dx_mem_wr)));                        // R4
    AST_MW_FROM_XM: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stage_flush[MW]) && !$past(stage_hold[MW]))
        |-> (mw_rd == $past(xm_rd) && mw_reg_we == $past(xm_reg_we)
             && mw_alu_res == $past(xm_alu_res)));                      // R5
    AST_WB_BUBBLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(stage_flush[MW]) |-> !mw_reg_we);                         // R6

endmodule

// File: tb/pipe_stage_chain_tb.sv
module pipe_stage_chain_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  stage_flush = '0;
    logic [3:0]  stage_hold = '0;
    logic [31:0] if_instr = '0;
    logic [3:0]  id_alu_op = '0;
    logic        id_alu_imm = 1'b0, id_mem_rd = 1'b0, id_mem_wr = 1'b0;
    logic        id_reg_we = 1'b0, id_mem_to_reg = 1'b0;
    logic [4:0]  id_rd = '0;
    logic [31:0] id_rs_val = '0, id_rt_val = '0, id_imm = '0;
    logic [31:0] ex_alu_res = '0, mem_rdata = '0;

    logic [31:0] id_instr;
    logic [3:0]  dx_alu_op;
    logic        dx_alu_imm, dx_mem_rd, dx_mem_wr, dx_reg_we, dx_mem_to_reg;
    logic [4:0]  dx_rd;
    logic [31:0] dx_rs_val, dx_rt_val, dx_imm;
    logic [31:0] xm_alu_res, xm_store_val;
    logic        xm_mem_rd, xm_mem_wr, xm_reg_we, xm_mem_to_reg;
    logic [4:0]  xm_rd;
    logic [31:0] mw_rdata, mw_alu_res;
    logic        mw_reg_we, mw_mem_to_reg;
    logic [4:0]  mw_rd;

    always #5 clk = ~clk;

    pipe_stage_chain u_dut (
        .clk(clk), .rst(rst), .stage_flush(stage_flush), .stage_hold(stage_hold),
        .if_instr(if_instr), .id_alu_op(id_alu_op), .id_alu_imm(id_alu_imm),
        .id_mem_rd(id_mem_rd), .id_mem_wr(id_mem_wr), .id_reg_we(id_reg_we),
        .id_mem_to_reg(id_mem_to_reg), .id_rd(id_rd), .id_rs_val(id_rs_val),
        .id_rt_val(id_rt_val), .id_imm(id_imm), .ex_alu_res(ex_alu_res),
        .mem_rdata(mem_rdata), .id_instr(id_instr), .dx_alu_op(dx_alu_op),
        .dx_alu_imm(dx_alu_imm), .dx_mem_rd(dx_mem_rd), .dx_mem_wr(dx_mem_wr),
        .dx_reg_we(dx_reg_we), .dx_mem_to_reg(dx_mem_to_reg), .dx_rd(dx_rd),
        .dx_rs_val(dx_rs_val), .dx_rt_val(dx_rt_val), .dx_imm(dx_imm),
        .xm_alu_res(xm_alu_res), .xm_store_val(xm_store_val), .xm_mem_rd(xm_mem_rd),
        .xm_mem_wr(xm_mem_wr), .xm_reg_we(xm_reg_we), .xm_mem_to_reg(xm_mem_to_reg),
        .xm_rd(xm_rd), .mw_rdata(mw_rdata), .mw_alu_res(mw_alu_res),
        .mw_reg_we(mw_reg_we), .mw_mem_to_reg(mw_mem_to_reg), .mw_rd(mw_rd));

    // Expected slot contents, packed in a bench-chosen field order.
    logic [31:0]  e_fd = '0;
    logic [109:0] e_dx = '0;  // op4 imm1 mrd mwr we m2r rd5 rs32 rt32 imm32
    logic [72:0]  e_xm = '0;  // mrd mwr we m2r rd5 alu32 st32
    logic [70:0]  e_mw = '0;  // we m2r rd5 rdata32 alu32
    string t_fd = "R1", t_dx = "R1", t_xm = "R1", t_mw = "R1";
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    function automatic string tag_of(input logic r, input logic f, input logic h,
                                     input string normal);
        if (r) return "R1";
        if (f) return "R6";
        if (h) return "R7";
        return normal;
    endfunction

    function automatic logic [109:0] dx_inputs();
        return {id_alu_op, id_alu_imm, id_mem_rd, id_mem_wr, id_reg_we,
                id_mem_to_reg, id_rd, id_rs_val, id_rt_val, id_imm};
    endfunction

    task automatic model_edge();
        logic [72:0] old_xm = e_xm;
        logic [109:0] old_dx = e_dx;
        if (rst || stage_flush[3]) e_mw = '0;
        else if (!stage_hold[3]) e_mw = {old_xm[70:64], mem_rdata, old_xm[63:32]};
        if (rst || stage_flush[2]) e_xm = '0;
        else if (!stage_hold[2]) e_xm = {old_dx[104:96], ex_alu_res, old_dx[63:32]};
        if (rst || stage_flush[1]) e_dx = '0;
        else if (!stage_hold[1]) e_dx = dx_inputs();
        if (rst || stage_flush[0]) e_fd = '0;
        else if (!stage_hold[0]) e_fd = if_instr;
        t_fd = tag_of(rst, stage_flush[0], stage_hold[0], "R2");
        t_dx = tag_of(rst, stage_flush[1], stage_hold[1], "R3");
        t_xm = tag_of(rst, stage_flush[2], stage_hold[2], "R4");
        t_mw = tag_of(rst, stage_flush[3], stage_hold[3], "R5");
    endtask

    task automatic check_vec(input string tag, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check_vec(t_fd, "fd", 128'(id_instr), 128'(e_fd));
        check_vec(t_dx, "dx", 128'({dx_alu_op, dx_alu_imm, dx_mem_rd, dx_mem_wr,
                  dx_reg_we, dx_mem_to_reg, dx_rd, dx_rs_val, dx_rt_val, dx_imm}),
                  128'(e_dx));
        check_vec(t_xm, "xm", 128'({xm_mem_rd, xm_mem_wr, xm_reg_we, xm_mem_to_reg,
                  xm_rd, xm_alu_res, xm_store_val}), 128'(e_xm));
        check_vec(t_mw, "mw", 128'({mw_reg_we, mw_mem_to_reg, mw_rd, mw_rdata,
                  mw_alu_res}), 128'(e_mw));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_data();
        if_instr   = $urandom;
        {id_alu_op, id_alu_imm, id_mem_rd, id_mem_wr, id_reg_we, id_mem_to_reg}
                   = 9'($urandom);
        id_rd      = 5'($urandom);
        id_rs_val  = $urandom;
        id_rt_val  = $urandom;
        id_imm     = $urandom;
        ex_alu_res = $urandom;
        mem_rdata  = $urandom;
    endtask

    task automatic rand_ctrl(input int pct);
        for (int k = 0; k < 4; k++) begin
            stage_flush[k] = (($urandom % 100) < pct);
            stage_hold[k]  = (($urandom % 100) < pct);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        rand_data();
        step();                      // R1: reset edge loads bubbles
        rst = 1'b0;

        // Plain streaming: R2..R5
        for (int i = 0; i < 40; i++) begin
            rand_data();
            stage_flush = '0; stage_hold = '0;
            step();
        end

        // R8: one destination index walks from decode/execute to writeback
        rand_data();
        id_rd = 5'd27; id_reg_we = 1'b1;
        step();
        rand_data();
        id_rd = 5'd3; id_reg_we = 1'b0;
        step();
        rand_data();
        step();
        n_chk++;
        if (mw_rd !== 5'd27 || mw_reg_we !== 1'b1) begin
            n_bad++;
            $display("FAIL R8 mw_rd/we actual=%0d/%0b expected=27/1", mw_rd, mw_reg_we);
        end

        // R6: flush and hold together on every slot
        rand_data();
        stage_flush = 4'hF; stage_hold = 4'hF;
        step();
        n_chk++;
        if (mw_reg_we !== 1'b0 || xm_mem_wr !== 1'b0 || id_instr !== 32'h0) begin
            n_bad++;
            $display("FAIL R6 enables actual=%b%b instr=%h expected=00 instr=0",
                     mw_reg_we, xm_mem_wr, id_instr);
        end

        // R7: fill, then hold decode/execute for several cycles while the rest moves
        stage_flush = '0; stage_hold = '0;
        rand_data();
        step();
        for (int i = 0; i < 5; i++) begin
            rand_data();
            stage_hold = 4'b0010;
            step();
        end
        stage_hold = '0;

        // Mixed random controls
        for (int i = 0; i < 400; i++) begin
            rand_data();
            rand_ctrl(15);
            step();
        end

        // R1: reset in the middle with nonzero contents
        stage_flush = '0; stage_hold = '0;
        rand_data();
        step();
        rst = 1'b1;
        rand_data();
        stage_hold = 4'hF;
        step();
        rst = 1'b0; stage_hold = '0;
        for (int i = 0; i < 20; i++) begin
            rand_data();
            rand_ctrl(30);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule